// File: doc/BRIEF.md
# Assignable Priority Interrupt Controller

This block gathers interrupt requests from a set of on-chip peripherals and from two external pins, and hands the CPU one answer per cycle: the most urgent interrupt level that is both pending and unmasked. There are eight levels, and the ordering between them is fixed. Which level a given source lands on is not fixed. A routing table gives every source its own level number and its own enable bit. Any number of sources may point at the same level, and they then share it.

Each external pin first passes through a two-stage synchroniser. It can then be used in one of two modes. In level mode the synchronised pin drives its source directly. In edge mode a rising transition sets a latch, and that latch holds until the CPU acknowledges the level the pin is routed to. Internal peripheral lines are always treated as level-sensitive. They stay pending for as long as the peripheral holds them high. A per-level mask decides which levels may be presented. The raw per-level pending vector is also brought out, so software can poll masked levels.

The chosen level, its valid flag and the pending vector are all registered. The CPU acknowledges a level by pulsing `ack_valid` for one cycle with the level number on `ack_level`.

Top module: `irq_ctrl`

## Requirements
- R1: After synchronous reset, every table entry is disabled with level 0 and level mode, the level mask is all zero, and `irq_valid`, `irq_level` and `irq_pend` are all zero. This holds even while every source line is high.
- R2: When an enabled internal source routed to level L goes high, `irq_pend[L]` is 1 after the next rising clock edge. If mask bit L is set and no higher level is pending, `irq_valid` is 1 and `irq_level` equals L after that same edge.
- R3: The levels are ordered with 7 the most urgent and 0 the least. `irq_level` is always the highest-numbered level that is both pending and unmasked.
- R4: A level shared by several enabled sources stays pending while at least one of them is active. It drops only when all of them are inactive.
- R5: A source whose enable bit is 0 has no effect on `irq_pend`, `irq_valid` or `irq_level`, whatever its level field holds.
- R6: A level whose bit in the mask written through `lvl_en_we`/`lvl_en_data` is 0 is never presented on `irq_level`, but it is still shown in `irq_pend`. With the whole mask at zero, `irq_valid` stays 0.
- R7: An external pin in level mode is seen through two synchronising flops. A pin that rises before clock edge k shows at the outputs after edge k+2, and it stops counting once the pin falls by the same path.
- R8: An external pin in edge mode (table bit `cfg_edge` = 1) latches each rising transition. The latch shows at the outputs after edge k+3, and it stays pending after the pin returns low.
- R9: An acknowledge of level L clears, at the next edge, the edge latches of all external pins routed to L. Latches on other levels and level-mode sources are not affected, and a level-mode pin that is still high stays pending.
- R10: External pin e is table entry N_INT+e (entries 8 and 9 with the defaults), and only these entries store the `cfg_edge` bit. `cfg_sel` values at or above N_INT+2 write nothing.
- R11: Only a low-to-high transition sets an edge latch. A pin held high across an acknowledge does not set the latch again until it has gone low and risen once more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_req | input | N_INT | Internal peripheral request lines, level-sensitive |
| ext_pin | input | N_EXT | Asynchronous external interrupt pins |
| cfg_we | input | 1 | Write strobe for one routing-table entry |
| cfg_sel | input | SEL_W | Index of the table entry to write |
| cfg_en | input | 1 | Enable bit written into the entry |
| cfg_edge | input | 1 | Edge-mode bit written into the entry (external entries only) |
| cfg_lvl | input | 3 | Level number written into the entry |
| lvl_en_we | input | 1 | Write strobe for the level mask |
| lvl_en_data | input | 8 | New level mask, bit L unmasks level L |
| ack_valid | input | 1 | One-cycle acknowledge pulse |
| ack_level | input | 3 | Level being acknowledged |
| irq_valid | output | 1 | An unmasked level is pending |
| irq_level | output | 3 | Most urgent unmasked pending level |
| irq_pend | output | 8 | Registered raw pending vector, before masking |

## Verification
A table of internal request patterns runs against one fixed routing. The patterns light a single source, two sources sharing a level, sources spread over several levels, a disabled source alone, and every source at once. Together they separate the priority choice from the sharing OR and from enable gating. The external pins are then exercised in both modes, counting edges to tell the two synchroniser flops from the extra latch stage. Acknowledges are aimed at the wrong level, at the right level, at a level-mode pin and at one of two latches pending on different levels, to show that clearing is selective. A held-high pin followed by a fresh rise shows that only transitions latch.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int LVL_W = 3;
    localparam int N_LVL = 1 << LVL_W;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [N_LVL-1:0] lvl_vec_t;

    // one routing-table entry
    typedef struct packed {
        logic en;
        logic edge_md;
        lvl_t lvl;
    } src_cfg_t;

    // what is presented to the CPU
    typedef struct packed {
        logic valid;
        lvl_t level;
    } irq_pick_t;

    // highest set bit wins; level N_LVL-1 is the most urgent
    function automatic irq_pick_t pick_top(lvl_vec_t v);
        irq_pick_t p;
        p = '0;
        for (int i = 0; i < N_LVL; i++) begin
            if (v[i]) begin
                p.valid = 1'b1;
                p.level = lvl_t'(i);
            end
        end
        return p;
    endfunction

    function automatic lvl_vec_t lvl_decode(lvl_t l);
        return lvl_vec_t'(1) << l;
    endfunction

endpackage

// File: rtl/irq_cfg_table.sv
module irq_cfg_table
    import irq_pkg::*;
#(
    parameter int N_INT = 8,
    parameter int N_SRC = 10,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             cfg_en,
    input  logic             cfg_edge,
    input  lvl_t             cfg_lvl,
    output src_cfg_t         cfg_q [N_SRC]
);

    for (genvar s = 0; s < N_SRC; s++) begin : g_entry
        localparam bit IS_EXT = (s >= N_INT);
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[s] <= '0;
            end else if (cfg_we && cfg_sel == SEL_W'(s)) begin
                cfg_q[s].en      <= cfg_en;
                cfg_q[s].edge_md <= IS_EXT ? cfg_edge : 1'b0;
                cfg_q[s].lvl     <= cfg_lvl;
            end
        end
    end

endmodule

// File: rtl/irq_ext_capture.sv
module irq_ext_capture
    import irq_pkg::*;
#(
    parameter int N_EXT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EXT-1:0] pin,
    input  logic [N_EXT-1:0] edge_md,
    input  lvl_t             pin_lvl [N_EXT],
    input  logic             ack_valid,
    input  lvl_t             ack_level,
    output logic [N_EXT-1:0] act
);

    logic [N_EXT-1:0] sync1_q, sync2_q, prev_q, latch_q;
    logic [N_EXT-1:0] rise, clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
        end else begin
            sync1_q <= pin;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign rise = sync2_q & ~prev_q;

    for (genvar e = 0; e < N_EXT; e++) begin : g_pin
        assign clr[e] = ack_valid && (ack_level == pin_lvl[e]);
        // a fresh edge in the same cycle as the acknowledge wins
        always_ff @(posedge clk) begin
            if (rst) latch_q[e] <= 1'b0;
            else     latch_q[e] <= edge_md[e] & (rise[e] | (latch_q[e] & ~clr[e]));
        end
        assign act[e] = edge_md[e] ? latch_q[e] : sync2_q[e];

        a_r8_latch_hold: assert property (@(posedge clk) disable iff (rst)
            (latch_q[e] && !clr[e] && edge_md[e]) |=> latch_q[e]);

        a_r9_ack_clear: assert property (@(posedge clk) disable iff (rst)
            (clr[e] && !rise[e]) |=> !latch_q[e]);

        a_r11_rise_only: assert property (@(posedge clk) disable iff (rst)
            (!latch_q[e] && $past(sync2_q[e]) && sync2_q[e]) |=> !latch_q[e]);
    end

endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
    import irq_pkg::*;
#(
    parameter int N_SRC = 10
) (
    input  src_cfg_t         cfg [N_SRC],
    input  logic [N_SRC-1:0] act,
    output lvl_vec_t         pend
);

    always_comb begin
        pend = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (act[s] && cfg[s].en) pend = pend | lvl_decode(cfg[s].lvl);
        end
    end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int N_INT = 8,
    parameter int N_EXT = 2,
    localparam int N_SRC = N_INT + N_EXT,
    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_INT-1:0] int_req,
    input  logic [N_EXT-1:0] ext_pin,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             cfg_en,
    input  logic             cfg_edge,
    input  logic [2:0]       cfg_lvl,
    input  logic             lvl_en_we,
    input  logic [7:0]       lvl_en_data,
    input  logic             ack_valid,
    input  logic [2:0]       ack_level,
    output logic             irq_valid,
    output logic [2:0]       irq_level,
    output logic [7:0]       irq_pend
);

    src_cfg_t         cfg_q [N_SRC];
    lvl_t             ext_lvl [N_EXT];
    logic [N_EXT-1:0] ext_edge;
    logic [N_EXT-1:0] ext_act;
    logic [N_SRC-1:0] src_act;
    logic [N_SRC-1:0] src_en;
    lvl_vec_t         pend_c;
    lvl_vec_t         lvl_en_q;
    irq_pick_t        pick;

    irq_cfg_table #(.N_INT(N_INT), .N_SRC(N_SRC), .SEL_W(SEL_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_en   (cfg_en),
        .cfg_edge (cfg_edge),
        .cfg_lvl  (cfg_lvl),
        .cfg_q    (cfg_q)
    );

    for (genvar e = 0; e < N_EXT; e++) begin : g_ext_cfg
        assign ext_lvl[e]  = cfg_q[N_INT+e].lvl;
        assign ext_edge[e] = cfg_q[N_INT+e].edge_md;
    end

    irq_ext_capture #(.N_EXT(N_EXT)) u_ext (
        .clk       (clk),
        .rst       (rst),
        .pin       (ext_pin),
        .edge_md   (ext_edge),
        .pin_lvl   (ext_lvl),
        .ack_valid (ack_valid),
        .ack_level (ack_level),
        .act       (ext_act)
    );

    assign src_act = {ext_act, int_req};

    for (genvar s = 0; s < N_SRC; s++) begin : g_en
        assign src_en[s] = cfg_q[s].en;
    end

    irq_level_map #(.N_SRC(N_SRC)) u_map (
        .cfg  (cfg_q),
        .act  (src_act),
        .pend (pend_c)
    );

    always_ff @(posedge clk) begin
        if (rst)            lvl_en_q <= '0;
        else if (lvl_en_we) lvl_en_q <= lvl_en_data;
    end

    assign pick = pick_top(pend_c & lvl_en_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_valid <= 1'b0;
            irq_level <= '0;
            irq_pend  <= '0;
        end else begin
            irq_valid <= pick.valid;
            irq_level <= pick.level;
            irq_pend  <= pend_c;
        end
    end

    // presented level is the top unmasked pending bit
    a_r3_top_level: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (((irq_pend & $past(lvl_en_q)) >> irq_level) == 8'd1));

    a_r6_valid_matches: assert property (@(posedge clk) disable iff (rst)
        irq_valid == (|(irq_pend & $past(lvl_en_q))));

    a_r5_disabled_silent: assert property (@(posedge clk) disable iff (rst)
        ((src_act & src_en) == '0) |=> (irq_pend == '0));

    a_r2_pend_follows: assert property (@(posedge clk) disable iff (rst)
        (|(src_act & src_en)) |=> (irq_pend != '0));

endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] int_req = '0;
    logic [1:0] ext_pin = '0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_sel = '0;
    logic       cfg_en = 1'b0;
    logic       cfg_edge = 1'b0;
    logic [2:0] cfg_lvl = '0;
    logic       lvl_en_we = 1'b0;
    logic [7:0] lvl_en_data = '0;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_level = '0;
    logic       irq_valid;
    logic [2:0] irq_level;
    logic [7:0] irq_pend;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_ctrl i_irq_ctrl (
        .clk (clk), .rst (rst), .int_req (int_req), .ext_pin (ext_pin),
        .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_en (cfg_en),
        .cfg_edge (cfg_edge), .cfg_lvl (cfg_lvl),
        .lvl_en_we (lvl_en_we), .lvl_en_data (lvl_en_data),
        .ack_valid (ack_valid), .ack_level (ack_level),
        .irq_valid (irq_valid), .irq_level (irq_level), .irq_pend (irq_pend)
    );

    typedef struct packed {
        logic [7:0] req;
        logic       v;
        logic [2:0] l;
        logic [7:0] p;
    } vec_t;

    // routing: s0->2 s1->5 s2->5 s3->7 s4 off(6) s5->0 s6->3 s7->1
    localparam vec_t VEC [11] = '{
        '{8'h00, 1'b0, 3'd0, 8'h00},
        '{8'h01, 1'b1, 3'd2, 8'h04},
        '{8'h06, 1'b1, 3'd5, 8'h20},
        '{8'h02, 1'b1, 3'd5, 8'h20},
        '{8'h04, 1'b1, 3'd5, 8'h20},
        '{8'h0B, 1'b1, 3'd7, 8'hA4},
        '{8'h10, 1'b0, 3'd0, 8'h00},
        '{8'h20, 1'b1, 3'd0, 8'h01},
        '{8'h21, 1'b1, 3'd2, 8'h05},
        '{8'hC0, 1'b1, 3'd3, 8'h0A},
        '{8'hFF, 1'b1, 3'd7, 8'hAF}
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 1:    return "R2";
            2, 3, 4: return "R4";
            6:       return "R5";
            default: return "R3";
        endcase
    endfunction

    task automatic check(string tag, logic v, logic [2:0] l, logic [7:0] p);
        checks++;
        if (irq_valid !== v || (v && irq_level !== l) || irq_pend !== p) begin
            errors++;
            $display("FAIL %s: got valid=%0b level=%0d pend=%02h, want valid=%0b level=%0d pend=%02h",
                     tag, irq_valid, irq_level, irq_pend, v, l, p);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(logic [3:0] sel, logic en, logic edg, logic [2:0] lvl);
        cfg_we = 1'b1; cfg_sel = sel; cfg_en = en; cfg_edge = edg; cfg_lvl = lvl;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic mask_write(logic [7:0] m);
        lvl_en_we = 1'b1; lvl_en_data = m;
        tick(1);
        lvl_en_we = 1'b0;
    endtask

    task automatic ack(logic [2:0] l);
        ack_valid = 1'b1; ack_level = l;
        tick(1);
        ack_valid = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int_req = 8'hFF;
        tick(3);
        rst = 1'b0;
        tick(1);
        check("R1 reset", 1'b0, 3'd0, 8'h00);
        int_req = 8'h00;

        cfg_write(4'd0, 1'b1, 1'b0, 3'd2);
        cfg_write(4'd1, 1'b1, 1'b0, 3'd5);
        cfg_write(4'd2, 1'b1, 1'b0, 3'd5);
        cfg_write(4'd3, 1'b1, 1'b0, 3'd7);
        cfg_write(4'd4, 1'b0, 1'b0, 3'd6);
        cfg_write(4'd5, 1'b1, 1'b0, 3'd0);
        cfg_write(4'd6, 1'b1, 1'b1, 3'd3);
        cfg_write(4'd7, 1'b1, 1'b0, 3'd1);
        cfg_write(4'd12, 1'b1, 1'b0, 3'd6); // out of range, R10
        mask_write(8'hFF);

        for (int i = 0; i < 11; i++) begin
            int_req = VEC[i].req;
            tick(1);
            check(vec_tag(i), VEC[i].v, VEC[i].l, VEC[i].p);
        end

        // R6 masking
        int_req = 8'h0A;
        mask_write(8'h7F);
        tick(1);
        check("R6 mask top", 1'b1, 3'd5, 8'hA0);
        mask_write(8'h00);
        tick(1);
        check("R6 mask all", 1'b0, 3'd0, 8'hA0);
        mask_write(8'hFF);
        int_req = 8'h00;
        tick(2);
        check("R10 bad index", 1'b0, 3'd0, 8'h00);

        // external pins: ext0 edge lvl6, ext1 level lvl4
        cfg_write(4'd8, 1'b1, 1'b1, 3'd6);
        cfg_write(4'd9, 1'b1, 1'b0, 3'd4);

        ext_pin[1] = 1'b1;
        tick(1); check("R7 sync1", 1'b0, 3'd0, 8'h00);
        tick(1); check("R7 sync2", 1'b0, 3'd0, 8'h00);
        tick(1); check("R7 level on", 1'b1, 3'd4, 8'h10);
        ext_pin[1] = 1'b0;
        tick(3); check("R7 level off", 1'b0, 3'd0, 8'h00);

        ext_pin[0] = 1'b1;
        tick(2);
        ext_pin[0] = 1'b0;
        tick(1); check("R8 latch stage", 1'b0, 3'd0, 8'h00);
        tick(1); check("R8 edge on", 1'b1, 3'd6, 8'h40);
        tick(4); check("R8 edge held", 1'b1, 3'd6, 8'h40);
        ack(3'd4);
        tick(1); check("R9 wrong level ack", 1'b1, 3'd6, 8'h40);
        ack(3'd6);
        tick(1); check("R9 ack clears", 1'b0, 3'd0, 8'h00);

        ext_pin[1] = 1'b1;
        tick(3); check("R9 level pin up", 1'b1, 3'd4, 8'h10);
        ack(3'd4);
        tick(2); check("R9 level survives ack", 1'b1, 3'd4, 8'h10);
        ext_pin[1] = 1'b0;
        tick(3);

        cfg_write(4'd9, 1'b1, 1'b1, 3'd4);
        ext_pin = 2'b11;
        tick(2);
        ext_pin = 2'b00;
        tick(2); check("R10 both latched", 1'b1, 3'd6, 8'h50);
        ack(3'd6);
        tick(1); check("R9 selective clear", 1'b1, 3'd4, 8'h10);
        ack(3'd4);
        tick(1); check("R9 second clear", 1'b0, 3'd0, 8'h00);

        ext_pin[0] = 1'b1;
        tick(4); check("R11 held pin latched", 1'b1, 3'd6, 8'h40);
        ack(3'd6);
        tick(1);
        tick(3); check("R11 no relatch", 1'b0, 3'd0, 8'h00);
        ext_pin[0] = 1'b0;
        tick(2);
        ext_pin[0] = 1'b1;
        tick(4); check("R11 new rise", 1'b1, 3'd6, 8'h40);
        ext_pin[0] = 1'b0;
        ack(3'd6);
        tick(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule